// File: doc/BRIEF.md
# Multichannel ADC Sequencer Controller

This block is the digital control for a 16-input, 12-bit successive-approximation converter front end. A host frames each conversion with an active-low frame strobe (`cs_n`) and supplies the serial clock, which is also the conversion clock (`clk`). The first rising clock edge that sees `cs_n` low samples the input and starts the conversion. Over the same 16 clocks the block shifts out a 16-bit frame on `sdo_o` and takes in a 16-bit control word on `sdi`.

The channel for each conversion is either one fixed channel or the next member of a programmed 16-bit channel set, visited in ascending order with wrap-around. Control bits choose the input span, the output coding, the idle behaviour of the serial output and the power mode. The power mode gates the reference/bias and converter core enables. The comparator itself is a behavioural stub that returns `sample_i` as the raw code.

Top module: `adcseq_ctrl`

## Requirements
- R1: A frame starts at the first rising edge with `cs_n` low while no frame is active. After the k-th edge of the frame (k = 1..16), `sdo_o` shows frame bit 16-k, and `sdo_drive_o` is 1 throughout. The frame is a 4-bit channel number followed by the 12-bit result, MSB first.
- R2: With the coding bit at 1, the result is the raw code (straight binary). With it at 0, the result is the raw code with its MSB inverted (two's complement about mid-scale).
- R3: The result is the value of `sample_i` at the frame's start edge. Later changes to `sample_i` within the frame have no effect.
- R4: Bits are captured on `sdi` at the 16 frame edges, MSB first. The word takes effect at the 16th edge only when bit 15 is 1. When bit 15 is 0, all settings stay as they were.
- R5: If `cs_n` rises before 16 edges are counted, the frame is aborted. `sdo_drive_o` goes low at the next edge, the control word is discarded and the channel does not advance.
- R6: A configuration word is one with bit 15 = 1 and bit 14 = 0. Its fields are: bit 13 sequence enable, bits 12:9 fixed channel, bits 8:7 power mode, bit 6 span, bit 5 coding, bit 4 idle keeper. With sequencing off, every later frame uses the fixed channel.
- R7: With sequencing on and a non-empty set, the first frame after the configuration uses the lowest channel in the set. Each completed frame then moves to the next higher channel in the set, wrapping from the highest to the lowest. A frame that writes the set advances using the set as it was before the write.
- R8: A set word is one with bits 15:14 = 11. Bit 13 selects the upper (1) or lower (0) half of the 16-bit channel set, and bits 7:0 replace that half.
- R9: Between frames `sdo_drive_o` is 0 and `sdo_keep_o` equals the idle-keeper bit. During a frame `sdo_keep_o` is 0.
- R10: Power mode 00 (normal) keeps `bias_on_o` and `core_on_o` at 1. Mode 01 (auto-standby) keeps bias on and turns the core on only during a frame. Mode 10 (auto-shutdown) turns both on only during a frame. Mode 11 (full shutdown) holds both at 0.
- R11: In full shutdown the 12-bit result field of each frame is zero. The channel field is still sent.
- R12: `hold_o` is 1 from the start edge until the 16th edge, and `mux_sel_o` shows the channel of the current or next conversion.
- R13: `range2x_o` follows the span bit. Reset values: fixed channel 0, sequencing off, normal power, span 0, coding 1, keeper 0, empty set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial/conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame strobe |
| sdi | input | 1 | Serial control word input |
| sample_i | input | 12 | Raw code returned by the comparator stub |
| sdo_o | output | 1 | Serial frame output |
| sdo_drive_o | output | 1 | Strong drive enable of the serial output |
| sdo_keep_o | output | 1 | Weak keeper enable of the serial output |
| mux_sel_o | output | 4 | Input multiplexer channel select |
| hold_o | output | 1 | Track/hold in hold state |
| range2x_o | output | 1 | Double span selected |
| bias_on_o | output | 1 | Reference and bias enable |
| core_on_o | output | 1 | Converter core enable |

## Verification
Frame bit 16-k is due just after the k-th rising edge of the frame. The bench drives every input on falling edges and reads `sdo_o` on the falling edge that follows each rising edge, so each of the 16 bits is read in its own half cycle. A control word committed at the 16th edge shows first in the channel, coding and power outputs of the next frame, and in the idle levels one edge after `cs_n` rises. An abort takes effect one edge after `cs_n` rises. The bench therefore checks idle outputs on the second falling edge after raising `cs_n`, and checks the effect of any setting only in the frame that follows its write.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int CH_W    = 4;
  localparam int CH_N    = 1 << CH_W;
  localparam int RES_W   = 12;
  localparam int FRAME_W = CH_W + RES_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int HALF_W  = 8;
  localparam int HALVES  = CH_N / HALF_W;

  // control word field positions
  localparam int CW_WR      = FRAME_W - 1;
  localparam int CW_TGT     = FRAME_W - 2;
  localparam int CW_SEQ     = FRAME_W - 3;
  localparam int CW_SEL     = FRAME_W - 3;
  localparam int CW_CH_LSB  = 9;
  localparam int CW_PWR_LSB = 7;
  localparam int CW_RANGE   = 6;
  localparam int CW_CODE    = 5;
  localparam int CW_KEEP    = 4;

  typedef enum logic [1:0] {
    PWR_NORMAL  = 2'b00,
    PWR_AUTOSTB = 2'b01,
    PWR_AUTOSHD = 2'b10,
    PWR_FULLSHD = 2'b11
  } pwr_mode_e;

  typedef struct packed {
    logic            seq_en;
    logic [CH_W-1:0] chan;
    pwr_mode_e       pwr;
    logic            range2x;
    logic            straight;
    logic            keep;
  } cfg_t;

  function automatic logic [RES_W-1:0] encode_result(
      input logic [RES_W-1:0] raw, input logic straight, input logic shut);
    if (shut) return '0;
    return straight ? raw : {~raw[RES_W-1], raw[RES_W-2:0]};
  endfunction

  function automatic logic [CH_W-1:0] next_enabled(
      input logic [CH_N-1:0] mask, input logic [CH_W-1:0] from);
    logic [CH_W-1:0] pick;
    logic [CH_W-1:0] idx;
    logic            found;
    pick  = from;
    found = 1'b0;
    for (int i = 1; i <= CH_N; i++) begin
      idx = from + CH_W'(i);
      if (!found && mask[idx]) begin
        pick  = idx;
        found = 1'b1;
      end
    end
    return pick;
  endfunction
endpackage

// File: rtl/adcseq_sar_stub.sv
module adcseq_sar_stub
  import adcseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [RES_W-1:0] sample_i,
  output logic [RES_W-1:0] raw
);
  logic [RES_W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held <= '0;
    else if (start) held <= sample_i;
  end

  assign raw = start ? sample_i : held;

  AST_SAMPLE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> held == $past(sample_i)); // R3
endmodule

// File: rtl/adcseq_frame.sv
module adcseq_frame
  import adcseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sdi,
  input  logic [CH_W-1:0]    chan,
  input  logic [RES_W-1:0]   code,
  output logic               active,
  output logic               conv_start,
  output logic               frame_done,
  output logic               frame_abort,
  output logic               hold,
  output logic               sdo,
  output logic [FRAME_W-1:0] ctl_word
);
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] ctl_q;
  logic [FRAME_W-1:0] shreg;
  logic               shift_en;
  logic               counting;

  assign counting    = cnt < CNT_W'(FRAME_W);
  assign conv_start  = !cs_n && !active;
  assign shift_en    = !cs_n && active && counting;
  assign frame_done  = shift_en && (cnt == CNT_W'(FRAME_W - 1));
  assign frame_abort = cs_n && active && counting;
  assign ctl_word    = {ctl_q[FRAME_W-2:0], sdi};
  assign hold        = active && counting;
  assign sdo         = active && shreg[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      ctl_q  <= '0;
      shreg  <= '0;
    end else if (cs_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (conv_start) begin
      active <= 1'b1;
      cnt    <= CNT_W'(1);
      ctl_q  <= {{(FRAME_W-1){1'b0}}, sdi};
      shreg  <= {chan, code};
    end else if (shift_en) begin
      cnt    <= cnt + CNT_W'(1);
      ctl_q  <= ctl_word;
      shreg  <= {shreg[FRAME_W-2:0], 1'b0};
    end
  end

  AST_START_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> hold && active); // R12
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !hold); // R12
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> !active); // R5
  AST_FIRST_BIT_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> sdo == $past(chan[CH_W-1])); // R1
endmodule

// File: rtl/adcseq_seq.sv
module adcseq_seq
  import adcseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_done,
  input  logic [FRAME_W-1:0] ctl_word,
  output cfg_t               cfg,
  output logic [CH_N-1:0]    mask,
  output logic [CH_W-1:0]    cur_ch
);
  localparam int SEL_W = (HALVES > 1) ? $clog2(HALVES) : 1;

  logic            wr, cfg_wr, mask_wr;
  cfg_t            new_cfg;
  logic [SEL_W-1:0] half_sel;
  logic [CH_W-1:0] first_ch, step_ch;

  assign wr       = frame_done && ctl_word[CW_WR];
  assign cfg_wr   = wr && !ctl_word[CW_TGT];
  assign mask_wr  = wr && ctl_word[CW_TGT];
  assign half_sel = ctl_word[CW_SEL -: SEL_W];

  always_comb begin
    new_cfg.seq_en   = ctl_word[CW_SEQ];
    new_cfg.chan     = ctl_word[CW_CH_LSB +: CH_W];
    new_cfg.pwr      = pwr_mode_e'(ctl_word[CW_PWR_LSB +: 2]);
    new_cfg.range2x  = ctl_word[CW_RANGE];
    new_cfg.straight = ctl_word[CW_CODE];
    new_cfg.keep     = ctl_word[CW_KEEP];
  end

  assign first_ch = (new_cfg.seq_en && |mask)
                    ? next_enabled(mask, CH_W'(CH_N - 1)) : new_cfg.chan;
  assign step_ch  = (cfg.seq_en && |mask) ? next_enabled(mask, cur_ch) : cfg.chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '{seq_en: 1'b0, chan: '0, pwr: PWR_NORMAL,
                  range2x: 1'b0, straight: 1'b1, keep: 1'b0};
      mask   <= '0;
      cur_ch <= '0;
    end else begin
      if (cfg_wr) begin
        cfg    <= new_cfg;
        cur_ch <= first_ch;
      end else if (frame_done) begin
        cur_ch <= step_ch;
      end
      if (mask_wr) begin
        for (int h = 0; h < HALVES; h++)
          if (half_sel == SEL_W'(h)) mask[h*HALF_W +: HALF_W] <= ctl_word[HALF_W-1:0];
      end
    end
  end

  AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg)); // R4
  AST_FIXED_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !cfg_wr && !cfg.seq_en) |=> cur_ch == cfg.chan); // R6
  AST_SEQ_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !wr && cfg.seq_en && |mask) |=> mask[cur_ch]); // R7
  AST_CHAN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(cur_ch)); // R5
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sdi,
  input  logic [RES_W-1:0] sample_i,
  output logic             sdo_o,
  output logic             sdo_drive_o,
  output logic             sdo_keep_o,
  output logic [CH_W-1:0]  mux_sel_o,
  output logic             hold_o,
  output logic             range2x_o,
  output logic             bias_on_o,
  output logic             core_on_o
);
  logic               active, conv_start, frame_done, frame_abort;
  logic [FRAME_W-1:0] ctl_word;
  logic [RES_W-1:0]   raw, code;
  cfg_t               cfg;
  logic [CH_N-1:0]    mask;
  logic [CH_W-1:0]    cur_ch;
  logic               full_shut;

  adcseq_sar_stub u_stub (
    .clk(clk), .rst_n(rst_n), .start(conv_start), .sample_i(sample_i), .raw(raw));

  assign full_shut = cfg.pwr == PWR_FULLSHD;
  assign code      = encode_result(raw, cfg.straight, full_shut);

  adcseq_frame u_frame (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi), .chan(cur_ch), .code(code),
    .active(active), .conv_start(conv_start), .frame_done(frame_done),
    .frame_abort(frame_abort), .hold(hold_o), .sdo(sdo_o), .ctl_word(ctl_word));

  adcseq_seq u_seq (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .ctl_word(ctl_word),
    .cfg(cfg), .mask(mask), .cur_ch(cur_ch));

  assign mux_sel_o   = cur_ch;
  assign sdo_drive_o = active;
  assign sdo_keep_o  = !active && cfg.keep;
  assign range2x_o   = cfg.range2x;

  always_comb begin
    unique case (cfg.pwr)
      PWR_NORMAL:  begin bias_on_o = 1'b1;   core_on_o = 1'b1;   end
      PWR_AUTOSTB: begin bias_on_o = 1'b1;   core_on_o = active; end
      PWR_AUTOSHD: begin bias_on_o = active; core_on_o = active; end
      default:     begin bias_on_o = 1'b0;   core_on_o = 1'b0;   end
    endcase
  end

  AST_DRIVE_KEEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdo_drive_o && sdo_keep_o)); // R9
  AST_FULLSHD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    full_shut |-> !core_on_o && !bias_on_o); // R10
  AST_ABORT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> !sdo_drive_o); // R5
endmodule

// File: tb/adcseq_ctrl_test.sv
module adcseq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  logic [11:0] sample_i = '0;
  logic        sdo_o, sdo_drive_o, sdo_keep_o, hold_o, range2x_o, bias_on_o, core_on_o;
  logic [3:0]  mux_sel_o;

  always #2 clk = ~clk;

  adcseq_ctrl uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi), .sample_i(sample_i),
    .sdo_o(sdo_o), .sdo_drive_o(sdo_drive_o), .sdo_keep_o(sdo_keep_o), .mux_sel_o(mux_sel_o),
    .hold_o(hold_o), .range2x_o(range2x_o), .bias_on_o(bias_on_o), .core_on_o(core_on_o));

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];

  // reference model of the settings
  logic        m_seq = 0, m_range = 0, m_straight = 1, m_keep = 0;
  logic [3:0]  m_chan = 0, m_cur = 0;
  logic [1:0]  m_pwr = 0;
  logic [15:0] m_mask = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] upnext(input logic [15:0] m, input logic [3:0] from);
    for (int d = 1; d <= 16; d++) begin
      int c = (int'(from) + d) % 16;
      if (m[c]) return 4'(c);
    end
    return from;
  endfunction

  function automatic logic exp_bias(input logic act);
    return (m_pwr == 2'd0) || (m_pwr == 2'd1) || (m_pwr == 2'd2 && act);
  endfunction
  function automatic logic exp_core(input logic act);
    return (m_pwr == 2'd0) || ((m_pwr == 2'd1 || m_pwr == 2'd2) && act);
  endfunction

  // monitor: gathers serial frames and compares against the scoreboard
  logic [15:0] got = 0;
  int          nbits = 0;
  always @(negedge clk) begin
    if (rst_n && sdo_drive_o) begin
      got = {got[14:0], sdo_o};
      nbits++;
      if (nbits == 16) begin
        nbits = 0;
        if (exp_q.size() == 0) chk("R1 unexpected frame", got, 16'hxxxx);
        else chk("R1/R2 frame content", got, exp_q.pop_front());
      end
    end else nbits = 0;
  end

  // driver: one frame of nclk edges; full frames push their expected content
  task automatic frame(input logic [15:0] ctl, input logic [11:0] smp,
                       input logic [11:0] late, input int nclk);
    logic [11:0] res;
    @(negedge clk);
    cs_n = 0; sdi = ctl[15]; sample_i = smp;
    res = (m_pwr == 2'd3) ? 12'h000 : (m_straight ? smp : smp ^ 12'h800);
    if (nclk == 16) exp_q.push_back({m_cur, res});
    for (int k = 0; k < nclk; k++) begin
      @(negedge clk);
      if (k == 0) begin
        chk("R12 hold during conversion", hold_o, 1'b1);
        chk("R12 mux select", mux_sel_o, m_cur);
        chk("R10 core during frame", core_on_o, exp_core(1'b1));
        chk("R10 bias during frame", bias_on_o, exp_bias(1'b1));
        chk("R9 keeper off in frame", sdo_keep_o, 1'b0);
        sample_i = late;
      end
      if (k == 15) chk("R12 hold released", hold_o, 1'b0);
      sdi = (k < 15) ? ctl[14-k] : 1'b0;
      if (k == nclk - 1) cs_n = 1;
    end
    if (nclk == 16) begin
      if (ctl[15] && !ctl[14]) begin
        m_seq = ctl[13]; m_chan = ctl[12:9]; m_pwr = ctl[8:7];
        m_range = ctl[6]; m_straight = ctl[5]; m_keep = ctl[4];
        m_cur = (m_seq && |m_mask) ? upnext(m_mask, 4'd15) : m_chan;
      end else begin
        m_cur = (m_seq && |m_mask) ? upnext(m_mask, m_cur) : m_chan;
        if (ctl[15]) begin
          if (ctl[13]) m_mask[15:8] = ctl[7:0];
          else         m_mask[7:0]  = ctl[7:0];
        end
      end
    end
    @(negedge clk);
    chk(nclk == 16 ? "R1 drive off after frame" : "R5 drive off after abort", sdo_drive_o, 1'b0);
    chk("R9 idle keeper", sdo_keep_o, m_keep);
    chk("R13 span output", range2x_o, m_range);
    chk("R10 idle bias", bias_on_o, exp_bias(1'b0));
    chk("R10 idle core", core_on_o, exp_core(1'b0));
    chk("R12 next channel", mux_sel_o, m_cur);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk("R13 reset drive", sdo_drive_o, 1'b0);
    chk("R13 reset keeper", sdo_keep_o, 1'b0);
    chk("R13 reset mux", mux_sel_o, 4'd0);
    chk("R13 reset hold", hold_o, 1'b0);
    chk("R13 reset span", range2x_o, 1'b0);
    chk("R10 reset power", {bias_on_o, core_on_o}, 2'b11);

    // R1 straight binary on channel 0, no write
    frame(16'h0000, 12'hABC, 12'h555, 16);
    // R6 fixed channel 5, two's complement, double span, keeper on (R2 R9 R13)
    frame(16'h8000 | (16'd5 << 9) | 16'h0040 | 16'h0010, 12'h3C1, 12'h000, 16);
    // R3 late sample change ignored; R2 coding applied
    frame(16'h0000, 12'h123, 12'hFFF, 16);
    // R4 word without write bit: sequence on, channel 9 requested but ignored
    frame(16'h7FFF & ((16'd1 << 13) | (16'd9 << 9)), 12'h800, 12'h001, 16);
    frame(16'h0000, 12'h7FF, 12'h7FF, 16);
    // R8 channel set: lower half {1,4}, upper half {15}
    frame(16'hC000 | 16'h0012, 12'h010, 12'h020, 16);
    frame(16'hE000 | 16'h0080, 12'h011, 12'h021, 16);
    // R7 sequencing on, straight, auto-shutdown (R10)
    frame(16'h8000 | (16'd1 << 13) | (16'd2 << 7) | 16'h0020, 12'hFFF, 12'h000, 16);
    frame(16'h0000, 12'h101, 12'h0, 16);
    frame(16'h0000, 12'h202, 12'h0, 16);
    frame(16'h0000, 12'h303, 12'h0, 16);
    // R5 aborted frame carrying a full-shutdown write
    frame(16'h8000 | (16'd3 << 7), 12'h444, 12'h0, 7);
    frame(16'h0000, 12'h404, 12'h0, 16);
    // R10 auto-standby, then R11 full shutdown
    frame(16'h8000 | (16'd1 << 7) | 16'h0020 | (16'd6 << 9), 12'h505, 12'h0, 16);
    frame(16'h0000, 12'h606, 12'h0, 16);
    frame(16'h8000 | (16'd3 << 7) | 16'h0020 | (16'd2 << 9), 12'h707, 12'h0, 16);
    frame(16'h0000, 12'hFED, 12'h0, 16);
    // R2 two's complement back in normal power
    frame(16'h8000 | (16'd12 << 9), 12'h9A5, 12'h0, 16);
    frame(16'h0000, 12'h9A5, 12'h0, 16);
    repeat (4) @(negedge clk);
    chk("R1 all frames seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule